// File: doc/BRIEF.md
# USB Line-State Reset and Speed Detector

This block watches the D+/D- pair while no packet is in flight and measures every single-ended-zero (SE0) interval, meaning both lines low. When the lines leave SE0 the measured length decides what the interval was. A long SE0 is a bus reset. A medium SE0 is a low-speed keep-alive, and it is reported only while the block holds low speed. An SE0 of a single sample is ignored as a glitch, because that level may be the first symbol of a packet. Both thresholds are cycle counts derived at compile time from the sample-clock frequency parameter.

The block also keeps the current signalling speed. A configured mode of full or low fixes the speed, and a bus reset brings the speed back to that mode. In automatic mode the speed follows the idle level that ends each classified SE0. D+ high marks a full-speed idle and D- high marks a low-speed idle. The raw lines pass through a synchronizer first. All lengths are counted in synchronized samples.

Top module: `usbse0_detector`

## Requirements
- R1: An SE0 length is the number of consecutive synchronized samples with both lines low, counted from the first such sample up to the first sample where either line is high. A length of 2 up to KA_CYC (12 at a 10 MHz sample clock) raises no pulse.
- R2: A length above RST_CYC = CLK_HZ/400000 samples (2.5 us; 25 at 10 MHz) raises `bus_rst_o`.
- R3: A length above KA_CYC = 3*CLK_HZ/2500000 samples (1.2 us; 12 at 10 MHz) and not above RST_CYC raises `keep_alive_o` only when `low_speed_o` was 1 as the SE0 ended. At full speed no pulse appears.
- R4: An SE0 of exactly one sample raises no pulse and leaves `low_speed_o` unchanged.
- R5: Each pulse lasts one cycle and comes once per SE0, a fixed few cycles after the lines leave SE0. The two pulses never coincide.
- R6: On a bus reset with `mode_i` = 2'b01 (full), `low_speed_o` becomes 0. With `mode_i` = 2'b10 (low), it becomes 1.
- R7: With `mode_i` = 2'b00 or 2'b11 (automatic), every SE0 longer than one sample updates the speed from the level that ends it. D+=1, D-=0 gives 0 (full). D+=0, D-=1 gives 1 (low). Both lines high keeps the speed.
- R8: In a fixed mode, an SE0 that is not a bus reset leaves `low_speed_o` unchanged.
- R9: The length counter saturates, so an SE0 of any duration beyond RST_CYC (40 or 200 samples, for example) still gives a bus reset.
- R10: After reset release both pulses are 0. `low_speed_o` is 1 if `mode_i` is 2'b10 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Raw D+ line |
| dm_i | input | 1 | Raw D- line |
| mode_i | input | 2 | Speed mode: 00/11 automatic, 01 full, 10 low |
| bus_rst_o | output | 1 | One-cycle bus reset pulse |
| keep_alive_o | output | 1 | One-cycle low-speed keep-alive pulse |
| low_speed_o | output | 1 | Current speed: 1 low, 0 full |

## Verification
If the length counter wraps or starts off by one, a pulse goes missing or appears at the threshold boundaries. The bench sweeps every length from 1 to 30 samples in every mode, so this shows in the first trial past a boundary. A speed register that updates on the wrong condition gives a wrong `low_speed_o` within a few cycles of the SE0 ending. It also turns a later medium-length SE0 into a missing or extra keep-alive. A sticky pulse shows as a pulse count above one in the window after release.

// File: rtl/usbse0_pkg.sv
package usbse0_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_FULL  = 2'b01,
    MODE_LOW   = 2'b10,
    MODE_AUTOX = 2'b11
  } mode_e;

  localparam logic SPD_FULL = 1'b0;
  localparam logic SPD_LOW  = 1'b1;

  typedef struct packed {
    logic dp;
    logic dm;
  } line_t;
endpackage

// File: rtl/usbse0_rstsync.sv
module usbse0_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= {q[0], 1'b1};
  end

  assign rst_ns = q[1];
endmodule

// File: rtl/usbse0_sync.sv
module usbse0_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  usbse0_pkg::line_t    raw_i,
  output usbse0_pkg::line_t    sync_o
);
  usbse0_pkg::line_t chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    usbse0_pkg::line_t d;
    if (g == 0) begin : g_first
      assign d = raw_i;
    end else begin : g_next
      assign d = chain[g-1];
    end
    // Reset to SE1: a non-SE0 level that never starts a measurement.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '{dp: 1'b1, dm: 1'b1};
      else        chain[g] <= d;
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/usbse0_timer.sv
module usbse0_timer #(
  parameter int CNT_W   = 8,
  parameter int CNT_MAX = 121
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se0_i,
  output logic             end_o,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             in_se0_q, in_se0_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    in_se0_d = se0_i;
    cnt_en   = se0_i && (!in_se0_q || cnt_q != SAT);
    cnt_d    = in_se0_q ? cnt_q + ONE : ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_se0_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      in_se0_q <= in_se0_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign end_o = in_se0_q && !se0_i;
  assign len_o = cnt_q;
endmodule

// File: rtl/usbse0_class.sv
module usbse0_class
  import usbse0_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RST_CYC = 120,
  parameter int KA_CYC  = 57
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_i,
  input  logic [CNT_W-1:0] len_i,
  input  line_t            level_i,
  input  logic [1:0]       mode_i,
  output logic             rst_o,
  output logic             ka_o,
  output logic             spd_o,
  output logic             init_o
);
  localparam logic [CNT_W-1:0] RST_L = CNT_W'(RST_CYC);
  localparam logic [CNT_W-1:0] KA_L  = CNT_W'(KA_CYC);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  mode_e mode;
  logic  valid, is_rst, is_ka, is_auto;
  logic  spd_d, spd_en;
  logic  rst_q, ka_q, spd_q, init_q;

  always_comb begin
    mode    = mode_e'(mode_i);
    is_auto = (mode == MODE_AUTO) || (mode == MODE_AUTOX);
    valid   = end_i && (len_i > ONE);
    is_rst  = valid && (len_i > RST_L);
    is_ka   = valid && !is_rst && (len_i > KA_L) && (spd_q == SPD_LOW);

    spd_d = spd_q;
    if (init_q) begin
      spd_d = (mode == MODE_LOW) ? SPD_LOW : SPD_FULL;
    end else begin
      if (is_rst && mode == MODE_FULL) spd_d = SPD_FULL;
      if (is_rst && mode == MODE_LOW)  spd_d = SPD_LOW;
      if (valid && is_auto) begin
        if (level_i.dp && !level_i.dm)      spd_d = SPD_FULL;
        else if (!level_i.dp && level_i.dm) spd_d = SPD_LOW;
      end
    end
    spd_en = init_q || valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      ka_q   <= 1'b0;
      spd_q  <= SPD_FULL;
      init_q <= 1'b1;
    end else begin
      rst_q  <= is_rst;
      ka_q   <= is_ka;
      init_q <= 1'b0;
      if (spd_en) spd_q <= spd_d;
    end
  end

  assign rst_o  = rst_q;
  assign ka_o   = ka_q;
  assign spd_o  = spd_q;
  assign init_o = init_q;
endmodule

// File: rtl/usbse0_detector.sv
module usbse0_detector
  import usbse0_pkg::*;
#(
  parameter int CLK_HZ      = 48_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic [1:0] mode_i,
  output logic       bus_rst_o,
  output logic       keep_alive_o,
  output logic       low_speed_o
);
  localparam int RST_CYC = CLK_HZ / 400_000;
  localparam int KA_CYC  = (CLK_HZ * 3) / 2_500_000;
  localparam int CNT_MAX = RST_CYC + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             rst_ns;
  line_t            raw, lvl;
  logic             se0_end;
  logic [CNT_W-1:0] se0_len;
  logic             spd_init;

  assign raw = '{dp: dp_i, dm: dm_i};

  usbse0_rstsync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  usbse0_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .raw_i(raw), .sync_o(lvl)
  );

  usbse0_timer #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .se0_i(!lvl.dp && !lvl.dm),
    .end_o(se0_end), .len_o(se0_len)
  );

  usbse0_class #(.CNT_W(CNT_W), .RST_CYC(RST_CYC), .KA_CYC(KA_CYC)) u_cls (
    .clk(clk), .rst_n(rst_ns), .end_i(se0_end), .len_i(se0_len),
    .level_i(lvl), .mode_i(mode_i), .rst_o(bus_rst_o),
    .ka_o(keep_alive_o), .spd_o(low_speed_o), .init_o(spd_init)
  );
endmodule

// File: rtl/usbse0_chk.sv
module usbse0_chk #(
  parameter int CNT_W   = 8,
  parameter int CNT_MAX = 121
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             spd_i,
  input logic             rst_p,
  input logic             ka_p,
  input logic             end_ev,
  input logic [CNT_W-1:0] len,
  input logic             init
);
  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_p |=> !rst_p);
  p_ka_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ka_p |=> !ka_p);
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_p && ka_p));
  p_ka_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ka_p |-> $past(spd_i));
  p_short_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(end_ev && len == CNT_W'(1)) |-> (!rst_p && !ka_p));
  p_spd_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spd_i) |-> $past(init || (end_ev && len > CNT_W'(1))));
  p_fixed_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_p && $past(mode_i) == 2'b01) |-> !spd_i);
  p_fixed_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_p && $past(mode_i) == 2'b10) |-> spd_i);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len <= CNT_W'(CNT_MAX));
endmodule

bind usbse0_detector usbse0_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_ns), .mode_i(mode_i), .spd_i(low_speed_o),
  .rst_p(bus_rst_o), .ka_p(keep_alive_o), .end_ev(se0_end),
  .len(se0_len), .init(spd_init)
);

// File: tb/sim_usbse0_detector.sv
module sim_usbse0_detector;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000_000;
  localparam int RST_N      = CLK_HZ / 400_000;
  localparam int KA_N       = (CLK_HZ * 3) / 2_500_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp = 1'b1, dm = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       brst, kal, lspd;

  int checks = 0;
  int fails  = 0;
  bit exp_spd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbse0_detector #(.CLK_HZ(CLK_HZ), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .mode_i(mode),
    .bus_rst_o(brst), .keep_alive_o(kal), .low_speed_o(lspd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; dp = 1'b1; dm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    exp_spd = (m == 2'b10);
    chk(brst == 1'b0, "R10 reset pulse", int'(brst), 0);
    chk(kal == 1'b0, "R10 keep-alive", int'(kal), 0);
    chk(lspd == exp_spd, "R10 speed", int'(lspd), int'(exp_spd));
  endtask

  task automatic trial(input logic [1:0] m, input int n, input bit rdp, input bit rdm);
    int  nr = 0, nk = 0;
    bit  valid, er, ek, autom;
    string tag;
    @(negedge clk);
    mode = m; dp = 1'b0; dm = 1'b0;
    repeat (n) @(negedge clk);
    dp = rdp; dm = rdm;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (brst) nr++;
      if (kal)  nk++;
    end
    valid = (n > 1);
    er    = valid && (n > RST_N);
    ek    = valid && !er && (n > KA_N) && exp_spd;
    autom = (m == 2'b00) || (m == 2'b11);
    if (er && m == 2'b01) exp_spd = 1'b0;
    if (er && m == 2'b10) exp_spd = 1'b1;
    if (valid && autom) begin
      if (rdp && !rdm)      exp_spd = 1'b0;
      else if (!rdp && rdm) exp_spd = 1'b1;
    end
    if (n == 1)           tag = "R4";
    else if (n > 30)      tag = "R9";
    else if (n > RST_N)   tag = "R2";
    else if (n > KA_N)    tag = "R3";
    else                  tag = "R1";
    chk(nr == int'(er), $sformatf("%s/R5 reset pulses n=%0d mode=%0d", tag, n, m), nr, int'(er));
    chk(nk == int'(ek), $sformatf("%s/R5 keep-alive pulses n=%0d mode=%0d", tag, n, m), nk, int'(ek));
    if (n == 1)      tag = "R4";
    else if (autom)  tag = "R7";
    else if (er)     tag = "R6";
    else             tag = "R8";
    chk(lspd == exp_spd, $sformatf("%s speed n=%0d mode=%0d", tag, n, m), int'(lspd), int'(exp_spd));
  endtask

  task automatic sweep(input logic [1:0] m);
    for (int n = 1; n <= 32; n++) begin
      int len;
      len = (n == 31) ? 40 : ((n == 32) ? 200 : n);
      case (n % 3)
        0: trial(m, len, 1'b1, 1'b0);
        1: trial(m, len, 1'b0, 1'b1);
        default: trial(m, len, 1'b1, 1'b1);
      endcase
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(2'b01);
    sweep(2'b00);
    sweep(2'b01);
    do_reset(2'b10);
    sweep(2'b10);
    do_reset(2'b00);
    sweep(2'b11);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule